// File: doc/BRIEF.md
# Bit-banged serial EEPROM port

This block gives software direct, bit-level control over a serial configuration EEPROM. A single 8-bit control/status register holds the chip-select level, the clock level, the data value and a data output enable. A read returns those stored bits, the live level on the data pin and two elapsed-time flags. Software toggles the pins through register writes to carry out any serial EEPROM protocol itself.

The two flags let software pace its accesses without counting cycles. A fixed tick fires every 70 bus clock cycles. Any register write clears both flags and restarts the tick counter. On each tick the first flag sets and the second flag takes the first flag's old value. So the first flag shows that at least 70 cycles have passed since the last write, and the second flag shows that at least 140 have passed.

After reset an internal configuration loader owns the pins, signalled by `loaderBusy`. While it does, the loader's pin values go to the pins. Register writes are still stored, but they reach the pins only once the loader releases them.

Top module: `eepromBitBangPort`

## Requirements
- R1: After reset the stored register bits are all 0: bits 0-3, 5, 6 and 7 read 0, and with the loader idle the clock, chip-select, data-out and output-enable pins are 0.
- R2: With the loader idle, register bit 0 drives `eeDoOut` and bit 1 drives `eeDoOe`; `eeDoOe`=0 means the data line is released.
- R3: With the loader idle, register bit 2 drives `eeClk` and bit 3 drives `eeCs`, one cycle after the write.
- R4: Read bit 4 equals the present level of `eeDiIn` in the same cycle, whatever was written to bit 4.
- R5: Bit 5 always reads 0, and writes to it have no effect.
- R6: Bit 6 reads 0 right after any write and becomes 1 exactly 70 clock edges after the write edge.
- R7: On each tick bit 7 loads the old value of bit 6, so after a write it becomes 1 exactly 140 edges after the write edge. Any write clears it.
- R8: While `loaderBusy`=1 the four pin outputs follow `ldCs`, `ldClk`, `ldDo` and `ldOe`. Writes in that time are still stored, and they appear on the pins once `loaderBusy` falls.
- R9: A write in the same cycle as a tick takes priority: both flags end up 0, and the next tick comes 70 edges after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| loaderBusy | input | 1 | 1 while the configuration loader owns the pins |
| ldCs | input | 1 | Loader chip-select |
| ldClk | input | 1 | Loader clock |
| ldDo | input | 1 | Loader data value |
| ldOe | input | 1 | Loader data output enable |
| eeCs | output | 1 | EEPROM chip-select pin |
| eeClk | output | 1 | EEPROM clock pin |
| eeDoOut | output | 1 | Value driven on the data line |
| eeDoOe | output | 1 | Data line output enable (0 = released) |
| eeDiIn | input | 1 | Sampled level of the data line |

## Verification
The hardest case to reach from the ports is a write that lands exactly on a tick cycle. No output shows the tick counter, so the bench counts clock edges from a known write and issues a second write on edge 70. It then checks that the flags stay clear and that the first flag sets only 70 edges later. The register map itself is covered by sweeping all 256 write values, once with the loader idle and once with it busy.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef struct packed {
    logic wr;    // register write accepted this cycle
    logic tick;  // elapsed-time tick, suppressed by a write
  } eepStrb_t;

  localparam int unsigned BIT_DO   = 0;
  localparam int unsigned BIT_OE   = 1;
  localparam int unsigned BIT_CLK  = 2;
  localparam int unsigned BIT_CS   = 3;
  localparam int unsigned BIT_DI   = 4;
  localparam int unsigned BIT_RSV  = 5;
  localparam int unsigned BIT_FLG1 = 6;
  localparam int unsigned BIT_FLG2 = 7;
endpackage

// File: rtl/eepCtrl.sv
module eepCtrl
  import eep_pkg::*;
#(
  parameter int unsigned TICK_PERIOD = 70
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  output eepStrb_t strb
);
  localparam int unsigned CNT_W = $clog2(TICK_PERIOD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_PERIOD - 1);

  logic [CNT_W-1:0] tickCnt;
  logic atLast;

  assign atLast    = (tickCnt == CNT_LAST);
  assign strb.wr   = wrEn;
  assign strb.tick = atLast && !wrEn;

  always_ff @(posedge clk) begin
    if (!rstN)             tickCnt <= '0;
    else if (wrEn || atLast) tickCnt <= '0;
    else                   tickCnt <= tickCnt + 1'b1;
  end

  // counter never leaves its modulo range
  always_comb begin
    if (rstN) assert (tickCnt <= CNT_LAST) else $error("p_cnt_range_r6");
  end

  p_write_restarts_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (tickCnt == '0));

  p_tick_wraps_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> (tickCnt == '0));
endmodule

// File: rtl/eepDatapath.sv
module eepDatapath
  import eep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  eepStrb_t   strb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       loaderBusy,
  input  logic       ldCs,
  input  logic       ldClk,
  input  logic       ldDo,
  input  logic       ldOe,
  output logic       eeCs,
  output logic       eeClk,
  output logic       eeDoOut,
  output logic       eeDoOe,
  input  logic       eeDiIn
);
  logic regDo, regOe, regClk, regCs;
  logic flg1, flg2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regDo <= 1'b0; regOe <= 1'b0; regClk <= 1'b0; regCs <= 1'b0;
    end else if (strb.wr) begin
      regDo  <= wrData[BIT_DO];
      regOe  <= wrData[BIT_OE];
      regClk <= wrData[BIT_CLK];
      regCs  <= wrData[BIT_CS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.wr) begin
      flg1 <= 1'b0;
      flg2 <= 1'b0;
    end else if (strb.tick) begin
      flg2 <= flg1;
      flg1 <= 1'b1;
    end
  end

  assign eeCs    = loaderBusy ? ldCs  : regCs;
  assign eeClk   = loaderBusy ? ldClk : regClk;
  assign eeDoOut = loaderBusy ? ldDo  : regDo;
  assign eeDoOe  = loaderBusy ? ldOe  : regOe;

  assign rdData = {flg2, flg1, 1'b0, eeDiIn, regCs, regClk, regOe, regDo};

  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |=> (!rdData[BIT_FLG1] && !rdData[BIT_FLG2]));

  p_flag2_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flg2) |-> $past(flg1));

  p_flag1_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flg1) |-> $past(strb.tick));

  p_pin_follows_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && !loaderBusy) |=> (loaderBusy || (eeClk == $past(wrData[BIT_CLK]) &&
                                                eeCs  == $past(wrData[BIT_CS]))));
endmodule

// File: rtl/eepromBitBangPort.sv
module eepromBitBangPort
  import eep_pkg::*;
#(
  parameter int unsigned TICK_PERIOD = 70
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       loaderBusy,
  input  logic       ldCs,
  input  logic       ldClk,
  input  logic       ldDo,
  input  logic       ldOe,
  output logic       eeCs,
  output logic       eeClk,
  output logic       eeDoOut,
  output logic       eeDoOe,
  input  logic       eeDiIn
);
  eepStrb_t strb;

  eepCtrl #(.TICK_PERIOD(TICK_PERIOD)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .strb(strb)
  );

  eepDatapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .loaderBusy(loaderBusy), .ldCs(ldCs), .ldClk(ldClk), .ldDo(ldDo), .ldOe(ldOe),
    .eeCs(eeCs), .eeClk(eeClk), .eeDoOut(eeDoOut), .eeDoOe(eeDoOe), .eeDiIn(eeDiIn)
  );
endmodule

// File: tb/sim_eepromBitBangPort.sv
module sim_eepromBitBangPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic loaderBusy = 1'b0;
  logic ldCs = 1'b0, ldClk = 1'b0, ldDo = 1'b0, ldOe = 1'b0;
  logic eeCs, eeClk, eeDoOut, eeDoOe;
  logic eeDiIn = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eepromBitBangPort u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .loaderBusy(loaderBusy), .ldCs(ldCs), .ldClk(ldClk), .ldDo(ldDo), .ldOe(ldOe),
    .eeCs(eeCs), .eeClk(eeClk), .eeDoOut(eeDoOut), .eeDoOe(eeDoOe), .eeDiIn(eeDiIn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdData == 8'h00, "R1 rdData", rdData, 0);
    chk({eeCs, eeClk, eeDoOut, eeDoOe} == 4'b0, "R1 pins", {eeCs, eeClk, eeDoOut, eeDoOe}, 0);

    // R2 R3 R5: full sweep of write values, loader idle
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      regWrite(8'(v));
      e = {4'b0000, 4'(v)};
      chk(rdData == e, "R5 readback", rdData, e);
      chk(eeDoOut == v[0] && eeDoOe == v[1], "R2 data pins", {eeDoOe, eeDoOut}, v & 3);
      chk(eeClk == v[2] && eeCs == v[3], "R3 clk cs pins", {eeCs, eeClk}, (v >> 2) & 3);
    end

    // R4 live data level
    for (int k = 0; k < 4; k++) begin
      eeDiIn = k[0];
      #1;
      chk(rdData[4] == k[0], "R4 live di", rdData[4], k[0]);
    end
    eeDiIn = 1'b0;

    // R8 loader owns pins: sweep loader values and stored writes
    loaderBusy = 1'b1;
    for (int v = 0; v < 256; v++) begin
      {ldCs, ldClk, ldOe, ldDo} = 4'(v >> 4);
      regWrite(8'(v));
      chk({eeCs, eeClk, eeDoOe, eeDoOut} == 4'(v >> 4), "R8 loader pins",
          {eeCs, eeClk, eeDoOe, eeDoOut}, (v >> 4) & 15);
      chk(rdData[3:0] == 4'(v), "R8 stored", rdData[3:0], v & 15);
    end
    regWrite(8'h0A);
    {ldCs, ldClk, ldOe, ldDo} = 4'b0101;
    @(negedge clk);
    loaderBusy = 1'b0;
    #1;
    chk({eeCs, eeClk, eeDoOe, eeDoOut} == 4'b1010, "R8 handback",
        {eeCs, eeClk, eeDoOe, eeDoOut}, 4'b1010);

    // R6 R7 flag timing after a write
    regWrite(8'h00);
    chk(rdData[7:6] == 2'b00, "R6 cleared", rdData[7:6], 0);
    repeat (69) @(negedge clk);
    chk(rdData[6] == 1'b0, "R6 edge 69", rdData[6], 0);
    @(negedge clk);
    chk(rdData[7:6] == 2'b01, "R6 edge 70", rdData[7:6], 1);
    repeat (69) @(negedge clk);
    chk(rdData[7] == 1'b0, "R7 edge 139", rdData[7], 0);
    @(negedge clk);
    chk(rdData[7:6] == 2'b11, "R7 edge 140", rdData[7:6], 3);
    regWrite(8'h00);
    chk(rdData[7:6] == 2'b00, "R7 cleared", rdData[7:6], 0);

    // R9 write coincident with tick (at negedge after edge 69)
    repeat (69) @(negedge clk);
    wrEn = 1'b1; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0;
    chk(rdData[7:6] == 2'b00, "R9 write wins", rdData[7:6], 0);
    repeat (69) @(negedge clk);
    chk(rdData[6] == 1'b0, "R9 restart 69", rdData[6], 0);
    @(negedge clk);
    chk(rdData[7:6] == 2'b01, "R9 restart 70", rdData[7:6], 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule